// File: doc/BRIEF.md
# Oscillator Period-Count Measurement Core

This block is the digital half of an on-die temperature sensor. An external oscillator runs at a frequency that depends on temperature. The core measures that frequency indirectly. It chooses a fixed number of oscillator periods and counts the ticks of a reference clock that elapse while those periods pass. The count is left in a data register, where software turns it into a temperature. The reference clock is the bus clock, slowed by an optional prescaler.

Software drives the core through a small memory-mapped register set. It sets the enable bit and then waits for the ready flag, which appears after a fixed startup delay. Once ready is up, setting the start bit makes the core measure window after window for as long as start stays set. Two read-only words hold the factory calibration constants. A threshold word and an interrupt-enable word are kept as plain storage so that a neighbouring comparator can use them.

Top module: `osc_period_meter`

## Requirements
- R1: After reset the configuration word reads 0x00000000, the status word (address 0x20) reads 0x00000000, and the data word (address 0x1C) reads 0x00000000.
- R2: The configuration word at 0x00 reads back these writable fields: enable (bit 0), start (bit 4), trigger select (bits 11:8), period count N (bits 19:16), reference select (bit 20), calibration option (bit 21) and prescaler D (bits 30:24). All other bits read 0, so writing all ones reads back 0x7F3F0F11.
- R3: Status bit 15 (ready) rises exactly STARTUP_CYC clock cycles after the clock edge that writes enable to 1.
- R4: Ready falls on the clock edge that follows the edge that writes enable to 0.
- R5: A start bit written while ready is low opens no window. Measurement begins only after ready rises.
- R6: With prescaler D equal to 0 or 1, and an oscillator period of P clock cycles, the data word bits 15:0 settle to M×P. M is N, except that N=0 counts as M=1.
- R7: With prescaler D of 2 or more, the data word settles to floor(M×P/D).
- R8: While start stays set, windows repeat back to back. A change of oscillator period is reflected in the data word without any new write.
- R9: Once start is cleared, no further window completes, and the data word keeps its last value even while the oscillator changes.
- R10: The count saturates at 0xFFFF instead of wrapping.
- R11: Address 0x08 reads {14'b0, calibration-temperature code (bits 17:16), base frequency (bits 15:0)}. Address 0x10 reads {16'b0, ramp coefficient}. Writes to both are ignored.
- R12: The data word reads 0 until the first window completes.
- R13: The threshold word at 0x14 reads back all 32 written bits. The interrupt-enable word at 0x24 keeps bits 2:0 and 6:4. The clear word at 0x28 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | Write strobe, qualified by busSel |
| busAddr | input | 6 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| oscIn | input | 1 | Asynchronous temperature-dependent oscillator |

## Verification
The hardest state to reach from the ports is a counter that is pinned at its ceiling. Getting there needs a window tens of thousands of cycles long, and that cost has to fit beside the startup delay and the random trials. The bench gets there by stretching the oscillator period to about 22000 cycles with N=3. It then polls the data word until the first long window closes. A second awkward case is a change of period during continuous running. Here the period is changed while start stays set, and the bench waits long enough for two clean windows before it compares.

// File: rtl/opm_pkg.sv
package opm_pkg;

  localparam logic [5:0] ADDR_CFG   = 6'h00;
  localparam logic [5:0] ADDR_FACTA = 6'h08;
  localparam logic [5:0] ADDR_FACTB = 6'h10;
  localparam logic [5:0] ADDR_THR   = 6'h14;
  localparam logic [5:0] ADDR_DATA  = 6'h1C;
  localparam logic [5:0] ADDR_STAT  = 6'h20;
  localparam logic [5:0] ADDR_IEN   = 6'h24;
  localparam logic [5:0] ADDR_ICLR  = 6'h28;

  localparam int READY_BIT = 15;
  localparam logic [31:0] IEN_MASK = 32'h0000_0077;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_COUNT
  } meas_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic openWin;
    logic countEn;
    logic closeWin;
    logic abortWin;
  } meas_strobe_t;

endpackage

// File: rtl/opm_regs.sv
module opm_regs
  import opm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int STARTUP_CYC = 2000,
  parameter logic [15:0] FACT_FREQ  = 16'h1A2B,
  parameter logic [1:0]  FACT_TCODE = 2'd1,
  parameter logic [15:0] FACT_RAMP  = 16'h00C5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [5:0]       busAddr,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  input  logic [CNT_W-1:0] dataVal,
  output logic             cfgEn,
  output logic             cfgStart,
  output logic [3:0]       smpTime,
  output logic [6:0]       presc,
  output logic             ready
);

  localparam int TMR_W = $clog2(STARTUP_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(STARTUP_CYC - 1);

  logic [3:0]  trigSel;
  logic        refSel;
  logic        calOpt;
  logic [31:0] thrQ;
  logic [6:0]  ienQ;
  logic [TMR_W-1:0] tmr;
  logic        wrEn;

  assign wrEn = busSel && busWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn    <= 1'b0;
      cfgStart <= 1'b0;
      trigSel  <= '0;
      smpTime  <= '0;
      refSel   <= 1'b0;
      calOpt   <= 1'b0;
      presc    <= '0;
      thrQ     <= '0;
      ienQ     <= '0;
    end else if (wrEn) begin
      case (busAddr)
        ADDR_CFG: begin
          cfgEn    <= busWdata[0];
          cfgStart <= busWdata[4];
          trigSel  <= busWdata[11:8];
          smpTime  <= busWdata[19:16];
          refSel   <= busWdata[20];
          calOpt   <= busWdata[21];
          presc    <= busWdata[30:24];
        end
        ADDR_THR: thrQ <= busWdata;
        ADDR_IEN: ienQ <= busWdata[6:0] & IEN_MASK[6:0];
        default: ;
      endcase
    end
  end

  // startup timer: ready comes up a fixed number of cycles after enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr   <= '0;
      ready <= 1'b0;
    end else if (!cfgEn) begin
      tmr   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (tmr == TMR_LAST) ready <= 1'b1;
      else                 tmr   <= tmr + 1'b1;
    end
  end

  logic [31:0] cfgWord;
  always_comb begin
    cfgWord        = '0;
    cfgWord[0]     = cfgEn;
    cfgWord[4]     = cfgStart;
    cfgWord[11:8]  = trigSel;
    cfgWord[19:16] = smpTime;
    cfgWord[20]    = refSel;
    cfgWord[21]    = calOpt;
    cfgWord[30:24] = presc;
  end

  always_comb begin
    busRdata = '0;
    if (busSel) begin
      case (busAddr)
        ADDR_CFG:   busRdata = cfgWord;
        ADDR_FACTA: busRdata = {14'b0, FACT_TCODE, FACT_FREQ};
        ADDR_FACTB: busRdata = {16'b0, FACT_RAMP};
        ADDR_THR:   busRdata = thrQ;
        ADDR_DATA:  busRdata = 32'(dataVal);
        ADDR_STAT:  busRdata = 32'(ready) << READY_BIT;
        ADDR_IEN:   busRdata = {25'b0, ienQ};
        default:    busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/opm_ctrl.sv
module opm_ctrl
  import opm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgEn,
  input  logic         cfgStart,
  input  logic         ready,
  input  logic         oscRise,
  input  logic         lastEdge,
  output meas_strobe_t strb
);

  meas_state_e state, stateNext;
  logic run;

  assign run = cfgEn && cfgStart && ready;

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      ST_IDLE: if (run) stateNext = ST_ARM;
      ST_ARM: begin
        if (!run) stateNext = ST_IDLE;
        else if (oscRise) begin
          strb.openWin = 1'b1;
          stateNext    = ST_COUNT;
        end
      end
      ST_COUNT: begin
        if (!run) begin
          strb.abortWin = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          strb.countEn = 1'b1;
          // closing edge doubles as the opening edge of the next window
          if (lastEdge) strb.closeWin = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/opm_datapath.sv
module opm_datapath
  import opm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscIn,
  input  logic [3:0]       smpTime,
  input  logic [6:0]       presc,
  input  meas_strobe_t     strb,
  output logic             oscRise,
  output logic             lastEdge,
  output logic [CNT_W-1:0] dataVal
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // synchroniser chain plus one history flop for edge detection
  logic [SYNC_STAGES:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], oscIn};
  end

  assign oscRise = syncQ[SYNC_STAGES-1] && !syncQ[SYNC_STAGES];

  logic [3:0] perTarget;
  logic [3:0] perCnt;
  logic [6:0] divLim;
  logic [6:0] divCnt;
  logic       tick;
  logic [CNT_W-1:0] cycCnt, cycNext;

  assign perTarget = (smpTime == 4'd0) ? 4'd1 : smpTime;
  assign divLim    = (presc == 7'd0) ? 7'd1 : presc;
  assign tick      = (divCnt == divLim - 7'd1);
  assign lastEdge  = oscRise && (perCnt == perTarget - 4'd1);
  assign cycNext   = (tick && cycCnt != CNT_MAX) ? cycCnt + 1'b1 : cycCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt  <= '0;
      perCnt  <= '0;
      divCnt  <= '0;
      dataVal <= '0;
    end else if (strb.openWin || strb.closeWin) begin
      cycCnt <= '0;
      perCnt <= '0;
      divCnt <= '0;
      if (strb.closeWin) dataVal <= cycNext;
    end else if (strb.countEn) begin
      cycCnt <= cycNext;
      divCnt <= tick ? 7'd0 : divCnt + 7'd1;
      if (oscRise) perCnt <= perCnt + 4'd1;
    end
  end

endmodule

// File: rtl/osc_period_meter.sv
module osc_period_meter
  import opm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int STARTUP_CYC = 2000,
  parameter logic [15:0] FACT_FREQ  = 16'h1A2B,
  parameter logic [1:0]  FACT_TCODE = 2'd1,
  parameter logic [15:0] FACT_RAMP  = 16'h00C5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [5:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        oscIn
);

  logic             cfgEn, cfgStart, ready;
  logic [3:0]       smpTime;
  logic [6:0]       presc;
  logic             oscRise, lastEdge;
  logic [CNT_W-1:0] dataVal;
  meas_strobe_t     strb;

  opm_regs #(
    .CNT_W(CNT_W), .STARTUP_CYC(STARTUP_CYC),
    .FACT_FREQ(FACT_FREQ), .FACT_TCODE(FACT_TCODE), .FACT_RAMP(FACT_RAMP)
  ) regs_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .dataVal(dataVal), .cfgEn(cfgEn), .cfgStart(cfgStart),
    .smpTime(smpTime), .presc(presc), .ready(ready)
  );

  opm_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgStart(cfgStart),
    .ready(ready), .oscRise(oscRise), .lastEdge(lastEdge), .strb(strb)
  );

  opm_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .oscIn(oscIn), .smpTime(smpTime),
    .presc(presc), .strb(strb), .oscRise(oscRise),
    .lastEdge(lastEdge), .dataVal(dataVal)
  );

endmodule

// File: rtl/opm_chk.sv
module opm_chk
  import opm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgEn,
  input logic             cfgStart,
  input logic             ready,
  input logic             oscRise,
  input meas_strobe_t     strb,
  input logic [CNT_W-1:0] dataVal
);

  // R4
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |=> !ready);

  // R3
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(cfgEn));

  // R5
  open_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.openWin |-> (cfgEn && cfgStart && ready));

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.closeWin |=> $stable(dataVal));

  // R6
  close_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.closeWin |-> oscRise);

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.openWin, strb.closeWin, strb.abortWin}));

endmodule

bind osc_period_meter opm_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgStart(cfgStart),
  .ready(ready), .oscRise(oscRise), .strb(strb), .dataVal(dataVal)
);

// File: tb/osc_period_meter_tb_top.sv
module osc_period_meter_tb_top;

  localparam int STARTUP = 2000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        oscIn = 1'b0;

  int compared = 0;
  int mismatched = 0;
  int oscPer = 10;
  bit oscOn = 1'b0;
  bit done = 1'b0;

  osc_period_meter #(.STARTUP_CYC(STARTUP)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .oscIn(oscIn)
  );

  always #10ns clk = ~clk;

  // oscillator model, period in clock cycles
  initial begin
    forever begin
      if (!oscOn) begin
        oscIn = 1'b0;
        @(negedge clk);
      end else begin
        oscIn = 1'b1;
        repeat (oscPer / 2) @(negedge clk);
        oscIn = 1'b0;
        repeat (oscPer - oscPer / 2) @(negedge clk);
      end
    end
  end

  function automatic logic [31:0] expCount(int n, int p, int d);
    int m = (n == 0) ? 1 : n;
    int dd = (d == 0) ? 1 : d;
    int v = (m * p) / dd;
    if (v > 65535) v = 65535;
    return 32'(v);
  endfunction

  function automatic logic [31:0] cfgWordOf(bit en, bit st, int n, int d);
    return 32'(en) | (32'(st) << 4) | (32'(n) << 16) | (32'(d) << 24);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(logic [5:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1ns;
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] held;
    int n, p, d, p2;
    void'($urandom(32'd20240611));

    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    busRead(6'h00, rd); check("R1 cfg", rd, 32'h0);
    busRead(6'h20, rd); check("R1 status", rd, 32'h0);
    busRead(6'h1C, rd); check("R1 data", rd, 32'h0);

    // R11 factory words, read-only
    busRead(6'h08, rd); check("R11 factory A", rd, 32'h0001_1A2B);
    busRead(6'h10, rd); check("R11 factory B", rd, 32'h0000_00C5);
    busWrite(6'h08, 32'hFFFF_FFFF);
    busWrite(6'h10, 32'h1234_5678);
    busRead(6'h08, rd); check("R11 factory A after write", rd, 32'h0001_1A2B);
    busRead(6'h10, rd); check("R11 factory B after write", rd, 32'h0000_00C5);

    // R13 storage words
    busWrite(6'h14, 32'hA5C3_0F96);
    busRead(6'h14, rd); check("R13 threshold", rd, 32'hA5C3_0F96);
    busWrite(6'h24, 32'hFFFF_FFFF);
    busRead(6'h24, rd); check("R13 irq enable", rd, 32'h0000_0077);
    busWrite(6'h28, 32'hFFFF_FFFF);
    busRead(6'h28, rd); check("R13 clear word", rd, 32'h0);

    // R2 readback mask
    busWrite(6'h00, 32'hFFFF_FFFF);
    busRead(6'h00, rd); check("R2 cfg mask", rd, 32'h7F3F_0F11);
    busWrite(6'h00, 32'h0);
    busRead(6'h00, rd); check("R2 cfg cleared", rd, 32'h0);
    idle(4);

    // R3 R5 R12: enable and start together before ready
    oscPer = 10;
    oscOn = 1'b1;
    idle(30);
    busWrite(6'h00, cfgWordOf(1, 1, 4, 0));
    idle(STARTUP - 1);
    busRead(6'h20, rd); check("R3 ready still low", rd, 32'h0);
    busRead(6'h1C, rd); check("R5 R12 no window before ready", rd, 32'h0);
    idle(1);
    busRead(6'h20, rd); check("R3 ready high", rd, 32'h0000_8000);
    idle((4 + 2) * 10 + 10);
    busRead(6'h1C, rd); check("R5 R6 first window", rd, expCount(4, 10, 0));

    // R6 R7 random trials
    for (int t = 0; t < 14; t++) begin
      n = $urandom_range(0, 15);
      p = $urandom_range(4, 40);
      case ($urandom_range(0, 4))
        0: d = 0;
        1: d = 1;
        2: d = 2;
        3: d = 3;
        default: d = 5;
      endcase
      busWrite(6'h00, cfgWordOf(1, 0, n, d));
      oscPer = p;
      idle(90);
      busWrite(6'h00, cfgWordOf(1, 1, n, d));
      idle(((n == 0 ? 1 : n) + 2) * p + 10);
      busRead(6'h1C, rd);
      if (d >= 2) check("R7 prescaled count", rd, expCount(n, p, d));
      else        check("R6 direct count", rd, expCount(n, p, d));
    end

    // directed: N=0 counts as one period, N=15 maximum
    busWrite(6'h00, cfgWordOf(1, 0, 0, 0));
    oscPer = 23; idle(90);
    busWrite(6'h00, cfgWordOf(1, 1, 0, 0));
    idle(3 * 23 + 10);
    busRead(6'h1C, rd); check("R6 N=0", rd, 32'd23);

    // R8 continuous: period change while start held
    busWrite(6'h00, cfgWordOf(1, 0, 15, 0));
    oscPer = 12; idle(90);
    busWrite(6'h00, cfgWordOf(1, 1, 15, 0));
    idle(17 * 12 + 10);
    busRead(6'h1C, rd); check("R6 N=15", rd, 32'd180);
    p2 = 20;
    oscPer = p2;
    idle(2 * 17 * p2 + 20);
    busRead(6'h1C, rd); check("R8 follows new period", rd, 32'd300);

    // R9 stop holds data
    busWrite(6'h00, cfgWordOf(1, 0, 15, 0));
    busRead(6'h1C, rd);
    held = rd;
    oscPer = 7;
    idle(17 * 20 + 40);
    busRead(6'h1C, rd); check("R9 data held after stop", rd, held);

    // R10 saturation
    busWrite(6'h00, cfgWordOf(1, 0, 3, 0));
    oscPer = 22000;
    idle(30);
    busWrite(6'h00, cfgWordOf(1, 1, 3, 0));
    begin
      int waited = 0;
      rd = '0;
      while (rd != 32'h0000_FFFF && waited < 110000) begin
        idle(1);
        waited++;
        busRead(6'h1C, rd);
      end
    end
    check("R10 saturated count", rd, 32'h0000_FFFF);

    // R4 enable cleared drops ready one edge later
    busWrite(6'h00, cfgWordOf(0, 1, 3, 0));
    busRead(6'h20, rd); check("R4 ready before drop", rd, 32'h0000_8000);
    idle(1);
    busRead(6'h20, rd); check("R4 ready dropped", rd, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule